// File: doc/BRIEF.md
# Credit-Based Virtual Channel Input Buffer

This block is the storage at one input port of an on-chip network router. Arriving flits are placed into per-virtual-channel queues. The channels are grouped into message classes. The first class carries control traffic, where every message is a single flit, so its channels are one flit deep. The remaining classes carry data messages, and their channels have a deeper, configurable queue. A channel holds the flits of only one message at a time. It is reserved when a head flit is written and released when that message's tail flit leaves.

The output port for a packet is computed from its head flit in the same cycle that the flit is written. Dimension-order routing is used: X first, then Y. The result is kept per channel for the switch allocators.

The switch stage reads each channel through its own valid/ready pair. Each accepted read returns one credit upstream in the same cycle. The flit input has a valid but no ready. The upstream router may send to a channel only while it holds a credit for it, so credits are the only back-pressure on the input side.

Top module: `vcbuf_input_port`

## Requirements
- R1: After reset every channel is empty and unreserved. `vc_valid`, `credit_valid` and `wr_err` are low.
- R2: A flit written with `flit_valid` goes into the queue selected by `flit_vc`, and that channel's occupancy is one higher at the next clock edge. Flits leave each queue in the order they were written.
- R3: Channels 0 to VCS_PER_CLASS-1 belong to the control class and hold CTRL_DEPTH flits (default 1). All higher channels hold DATA_DEPTH flits (default 4). Occupancy never exceeds the depth.
- R4: A write to a channel whose occupancy equals its depth at the start of the cycle is dropped, even if that channel is also read in the same cycle. The stored flits stay unchanged, and `wr_err` is high for exactly the cycle after the write.
- R5: When `vc_valid[v]` and `vc_ready[v]` are both high at a clock edge, the flit shown on `vc_data`/`vc_head`/`vc_tail` for channel v is removed. The next flit of that channel is presented afterwards.
- R6: In the cycle a flit is read, `credit_valid` is high and `credit_vc` holds the channel index. `credit_free` is high only if the flit read is a tail.
- R7: If several channels have valid and ready high together, only the lowest-indexed one is read and credited. The others keep their contents.
- R8: `vc_busy[v]` goes high after a head flit is written to channel v and goes low only after that message's tail flit is read. A single-flit message carries both head and tail.
- R9: The head flit's payload gives the destination: x in bits [COORD_W-1:0], y in bits [2*COORD_W-1:COORD_W]. The route is encoded as 0 local, 1 east (x greater than this router's), 2 west, 3 north (x equal, y greater), 4 south. The route is captured into `vc_route` at the head write and held until the next head.
- R10: A write and a read of the same channel in the same cycle, on a channel that is not full, leave its occupancy unchanged, and the new flit queues behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | Incoming flit present |
| flit_vc | input | VC_W | Target channel of the incoming flit |
| flit_head | input | 1 | Incoming flit starts a message |
| flit_tail | input | 1 | Incoming flit ends a message |
| flit_data | input | DATA_W | Incoming payload |
| vc_ready | input | NUM_VC | Per-channel read request from the switch stage |
| vc_valid | output | NUM_VC | Per-channel flit available |
| vc_head | output | NUM_VC | Head marker of each channel's front flit |
| vc_tail | output | NUM_VC | Tail marker of each channel's front flit |
| vc_data | output | NUM_VC*DATA_W | Payload of each channel's front flit |
| vc_route | output | NUM_VC*3 | Output port computed for each channel's message |
| vc_busy | output | NUM_VC | Channel reserved by a message |
| vc_occ | output | NUM_VC*OCC_W | Flits stored per channel |
| credit_valid | output | 1 | A credit is returned this cycle |
| credit_vc | output | VC_W | Channel the credit belongs to |
| credit_free | output | 1 | The credited flit was a tail; channel released |
| wr_err | output | 1 | Previous cycle's write hit a full channel and was dropped |

## Verification
The bench first fills a one-deep control channel and then a four-deep data channel, and writes once more into each. A design that wrapped its pointers would overwrite the front flit, and one that ignored the depth would raise the occupancy; either way `wr_err` or the front payload gives it away. The bench then raises ready on two channels at once. A selector with the wrong priority credits the higher channel, and one without a selector drains both. A write and a read on the same channel in one cycle catch occupancy counters that lose an update. Watching `vc_busy` across a multi-flit drain catches a reservation that is released on the head or a body flit instead of the tail.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/vcbuf_route.sv
module vcbuf_route
  import vcbuf_pkg::*;
#(
  parameter int COORD_W = 2,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input  logic [2*COORD_W-1:0] dest,
  output port_e                port
);
  logic [COORD_W-1:0] dx, dy;
  assign dx = dest[COORD_W-1:0];
  assign dy = dest[2*COORD_W-1:COORD_W];

  always_comb begin
    if (dx > COORD_W'(MY_X))      port = PORT_EAST;
    else if (dx < COORD_W'(MY_X)) port = PORT_WEST;
    else if (dy > COORD_W'(MY_Y)) port = PORT_NORTH;
    else if (dy < COORD_W'(MY_Y)) port = PORT_SOUTH;
    else                          port = PORT_LOCAL;
  end
endmodule

// File: rtl/vcbuf_vc_queue.sv
module vcbuf_vc_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int OCC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_head,
  input  logic              wr_tail,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        wr_route,
  input  logic              rd_en,
  output logic              out_valid,
  output logic              out_head,
  output logic              out_tail,
  output logic [DATA_W-1:0] out_data,
  output logic [2:0]        route,
  output logic              busy,
  output logic [OCC_W-1:0]  occ,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_data [DEPTH];
  logic              mem_head [DEPTH];
  logic              mem_tail [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [OCC_W-1:0]  occ_q;
  logic              busy_q;
  logic [2:0]        route_q;
  logic              accept;

  assign full      = (occ_q == OCC_W'(DEPTH));
  assign accept    = wr_en && !full;
  assign out_valid = (occ_q != '0);
  assign out_data  = mem_data[rd_ptr];
  assign out_head  = mem_head[rd_ptr];
  assign out_tail  = mem_tail[rd_ptr];
  assign occ       = occ_q;
  assign busy      = busy_q;
  assign route     = route_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_data[wr_ptr] <= wr_data;
      mem_head[wr_ptr] <= wr_head;
      mem_tail[wr_ptr] <= wr_tail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ_q   <= '0;
      busy_q  <= 1'b0;
      route_q <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (rd_en)  rd_ptr <= bump(rd_ptr);
      case ({accept, rd_en})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
      if (accept && wr_head)       busy_q <= 1'b1;
      else if (rd_en && out_tail)  busy_q <= 1'b0;
      if (accept && wr_head)       route_q <= wr_route;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R2
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !rd_en) |=> occ_q == $past(occ_q) + OCC_W'(1));

  // R4
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> $stable(occ_q));

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(rd_en && out_tail));
endmodule

// File: rtl/vcbuf_read_sel.sv
module vcbuf_read_sel #(
  parameter int NUM_VC = 8,
  parameter int VC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] valid,
  input  logic [NUM_VC-1:0] ready,
  output logic [NUM_VC-1:0] pop,
  output logic              credit_valid,
  output logic [VC_W-1:0]   credit_vc
);
  logic [NUM_VC-1:0] req;
  assign req = valid & ready;

  always_comb begin
    credit_valid = 1'b0;
    credit_vc    = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (!credit_valid && req[v]) begin
        credit_valid = 1'b1;
        credit_vc    = VC_W'(v);
      end
    end
    pop = credit_valid ? (NUM_VC'(1) << credit_vc) : '0;
  end

  // R7
  one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
endmodule

// File: rtl/vcbuf_input_port.sv
module vcbuf_input_port
  import vcbuf_pkg::*;
#(
  parameter int NUM_CLASSES   = 2,
  parameter int VCS_PER_CLASS = 4,
  parameter int CTRL_DEPTH    = 1,
  parameter int DATA_DEPTH    = 4,
  parameter int DATA_W        = 16,
  parameter int COORD_W       = 2,
  parameter int MY_X          = 1,
  parameter int MY_Y          = 1,
  localparam int NUM_VC       = NUM_CLASSES * VCS_PER_CLASS,
  localparam int VC_W         = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int MAX_DEPTH    = (CTRL_DEPTH > DATA_DEPTH) ? CTRL_DEPTH : DATA_DEPTH,
  localparam int OCC_W        = $clog2(MAX_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flit_valid,
  input  logic [VC_W-1:0]          flit_vc,
  input  logic                     flit_head,
  input  logic                     flit_tail,
  input  logic [DATA_W-1:0]        flit_data,
  input  logic [NUM_VC-1:0]        vc_ready,
  output logic [NUM_VC-1:0]        vc_valid,
  output logic [NUM_VC-1:0]        vc_head,
  output logic [NUM_VC-1:0]        vc_tail,
  output logic [NUM_VC*DATA_W-1:0] vc_data,
  output logic [NUM_VC*3-1:0]      vc_route,
  output logic [NUM_VC-1:0]        vc_busy,
  output logic [NUM_VC*OCC_W-1:0]  vc_occ,
  output logic                     credit_valid,
  output logic [VC_W-1:0]          credit_vc,
  output logic                     credit_free,
  output logic                     wr_err
);
  port_e             in_route;
  logic [NUM_VC-1:0] vc_full;
  logic [NUM_VC-1:0] vc_pop;
  logic              wr_err_q;

  vcbuf_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
    .dest (flit_data[2*COORD_W-1:0]),
    .port (in_route)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    localparam int DEP = (v < VCS_PER_CLASS) ? CTRL_DEPTH : DATA_DEPTH;
    logic sel;
    assign sel = flit_valid && (flit_vc == VC_W'(v));

    vcbuf_vc_queue #(.DEPTH(DEP), .DATA_W(DATA_W), .OCC_W(OCC_W)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sel),
      .wr_head   (flit_head),
      .wr_tail   (flit_tail),
      .wr_data   (flit_data),
      .wr_route  (in_route),
      .rd_en     (vc_pop[v]),
      .out_valid (vc_valid[v]),
      .out_head  (vc_head[v]),
      .out_tail  (vc_tail[v]),
      .out_data  (vc_data[v*DATA_W +: DATA_W]),
      .route     (vc_route[v*3 +: 3]),
      .busy      (vc_busy[v]),
      .occ       (vc_occ[v*OCC_W +: OCC_W]),
      .full      (vc_full[v])
    );
  end

  vcbuf_read_sel #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid        (vc_valid),
    .ready        (vc_ready),
    .pop          (vc_pop),
    .credit_valid (credit_valid),
    .credit_vc    (credit_vc)
  );

  assign credit_free = credit_valid && vc_tail[credit_vc];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_err_q <= 1'b0;
    else        wr_err_q <= flit_valid && vc_full[flit_vc];
  end
  assign wr_err = wr_err_q;

  // R6
  credit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_valid |-> (vc_valid[credit_vc] && vc_ready[credit_vc]));

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(flit_valid));
endmodule

// File: tb/vcbuf_input_port_tb.sv
module vcbuf_input_port_tb;
  localparam int NVC = 8;
  localparam int DW  = 16;
  localparam int OW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flit_valid = 1'b0;
  logic [2:0]    flit_vc = '0;
  logic          flit_head = 1'b0;
  logic          flit_tail = 1'b0;
  logic [DW-1:0] flit_data = '0;
  logic [NVC-1:0] vc_ready = '0;
  logic [NVC-1:0] vc_valid, vc_head, vc_tail, vc_busy;
  logic [NVC*DW-1:0] vc_data;
  logic [NVC*3-1:0]  vc_route;
  logic [NVC*OW-1:0] vc_occ;
  logic          credit_valid, credit_free, wr_err;
  logic [2:0]    credit_vc;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vcbuf_input_port u_dut (
    .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_vc(flit_vc),
    .flit_head(flit_head), .flit_tail(flit_tail), .flit_data(flit_data),
    .vc_ready(vc_ready), .vc_valid(vc_valid), .vc_head(vc_head),
    .vc_tail(vc_tail), .vc_data(vc_data), .vc_route(vc_route),
    .vc_busy(vc_busy), .vc_occ(vc_occ), .credit_valid(credit_valid),
    .credit_vc(credit_vc), .credit_free(credit_free), .wr_err(wr_err)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] vc;
    logic       h;
    logic       t;
    logic [15:0] d;
    logic [7:0] rdy;
    logic       cv;
    logic [2:0] cvc;
    logic       cf;
    logic [15:0] ed;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 3'd0, 1'b1, 1'b1, 16'h0011, 8'h00, 1'b0, 3'd0, 1'b0, 16'h0000},
    '{1'b1, 3'd4, 1'b1, 1'b0, 16'h0003, 8'h01, 1'b1, 3'd0, 1'b1, 16'h0011},
    '{1'b1, 3'd4, 1'b0, 1'b0, 16'h1234, 8'h00, 1'b0, 3'd0, 1'b0, 16'h0000},
    '{1'b1, 3'd4, 1'b0, 1'b1, 16'h00AA, 8'h10, 1'b1, 3'd4, 1'b0, 16'h0003},
    '{1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 8'h10, 1'b1, 3'd4, 1'b0, 16'h1234},
    '{1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 8'h10, 1'b1, 3'd4, 1'b1, 16'h00AA},
    '{1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 8'h10, 1'b0, 3'd0, 1'b0, 16'h0000},
    '{1'b1, 3'd1, 1'b1, 1'b1, 16'h0010, 8'h02, 1'b0, 3'd0, 1'b0, 16'h0000},
    '{1'b0, 3'd0, 1'b0, 1'b0, 16'h0000, 8'h12, 1'b1, 3'd1, 1'b1, 16'h0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [2:0] vc, input logic h, input logic t,
                     input logic [15:0] d, input logic [7:0] rdy);
    @(negedge clk);
    flit_valid = wr; flit_vc = vc; flit_head = h; flit_tail = t;
    flit_data = d; vc_ready = rdy;
  endtask

  function automatic logic [2:0] occ_of(input int v);
    return vc_occ[v*OW +: OW];
  endfunction
  function automatic logic [15:0] data_of(input int v);
    return vc_data[v*DW +: DW];
  endfunction
  function automatic logic [2:0] route_of(input int v);
    return vc_route[v*3 +: 3];
  endfunction

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] exp5 [4];
    exp5[0] = 16'h000D; exp5[1] = 16'h0101; exp5[2] = 16'h0202; exp5[3] = 16'h0303;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", vc_valid, 0);
    chk("R1 busy", vc_busy, 0);
    chk("R1 occ", vc_occ, 0);
    chk("R1 credit", credit_valid, 0);
    chk("R1 err", wr_err, 0);

    // R5 R6 table of writes and reads
    for (int i = 0; i < 9; i++) begin
      cyc(TBL[i].wr, TBL[i].vc, TBL[i].h, TBL[i].t, TBL[i].d, TBL[i].rdy);
      #1;
      chk("R6 credit_valid", credit_valid, TBL[i].cv);
      if (TBL[i].cv) begin
        chk("R6 credit_vc", credit_vc, TBL[i].cvc);
        chk("R6 credit_free", credit_free, TBL[i].cf);
        chk("R5 data", data_of(int'(TBL[i].cvc)), TBL[i].ed);
      end
    end

    // control VC depth and overflow drop
    cyc(1, 3'd2, 1, 1, 16'h000A, 0);
    cyc(1, 3'd2, 1, 1, 16'h00BB, 0);
    chk("R2 occ after write", occ_of(2), 1);
    chk("R9 route east", route_of(2), 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R4 err raised", wr_err, 1);
    chk("R3 ctrl depth", occ_of(2), 1);
    chk("R4 data kept", data_of(2), 16'h000A);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R4 err one cycle", wr_err, 0);
    cyc(0, 0, 0, 0, 0, 8'h04);
    cyc(0, 0, 0, 0, 0, 0);

    // data VC fill, overflow, drain
    cyc(1, 3'd5, 1, 0, 16'h000D, 0);
    cyc(1, 3'd5, 0, 0, 16'h0101, 0);
    cyc(1, 3'd5, 0, 0, 16'h0202, 0);
    cyc(1, 3'd5, 0, 1, 16'h0303, 0);
    cyc(1, 3'd5, 1, 1, 16'h0404, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R3 data depth", occ_of(5), 4);
    chk("R4 err data vc", wr_err, 1);
    chk("R9 route north", route_of(5), 3);
    chk("R8 busy set", vc_busy[5], 1);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 0, 8'h20);
      if (i == 3) chk("R8 busy held to tail", vc_busy[5], 1);
      #1;
      chk("R6 vc5 credit", {credit_valid, credit_vc}, {1'b1, 3'd5});
      chk("R5 order", data_of(5), exp5[i]);
      chk("R6 free on tail", credit_free, (i == 3));
    end
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 busy cleared", vc_busy[5], 0);
    chk("R5 drained", occ_of(5), 0);

    // R7 priority
    cyc(1, 3'd3, 1, 1, 16'h0004, 0);
    cyc(1, 3'd6, 1, 0, 16'h0005, 0);
    cyc(0, 0, 0, 0, 0, 8'h48);
    #1;
    chk("R7 lowest served", {credit_valid, credit_vc}, {1'b1, 3'd3});
    cyc(0, 0, 0, 0, 0, 0);
    chk("R7 other kept", occ_of(6), 1);
    chk("R7 winner popped", occ_of(3), 0);
    chk("R9 route local", route_of(6), 0);
    chk("R9 route west", route_of(3), 2);

    // R10 same-cycle write and read
    cyc(1, 3'd6, 0, 1, 16'h0606, 8'h40);
    #1;
    chk("R10 credit", {credit_valid, credit_vc, credit_free}, {1'b1, 3'd6, 1'b0});
    chk("R10 old front", data_of(6), 16'h0005);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R10 occ unchanged", occ_of(6), 1);
    chk("R10 new front", data_of(6), 16'h0606);
    chk("R8 busy until tail leaves", vc_busy[6], 1);
    cyc(0, 0, 0, 0, 0, 8'h40);
    #1;
    chk("R6 tail credit", credit_free, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 released", vc_busy[6], 0);

    // R8 single-flit message, R9 south
    cyc(1, 3'd7, 1, 1, 16'h0001, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 route south", route_of(7), 4);
    chk("R8 single busy", vc_busy[7], 1);
    cyc(0, 0, 0, 0, 0, 8'h80);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 single released", vc_busy[7], 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule